// File: doc/BRIEF.md
# Direction-Aware Branch Register Sequencer

This block sequences the program counter of a reversible processor. A branch does not load a target into the PC. A taken branch adds its offset into a signed branch register. Between instructions the PC then moves by that register's value, scaled by a forward/reverse direction bit. When the branch register is zero the PC moves by a single step in the current direction. The register keeps stepping the PC until it is cleared, normally by exchanging it with a zero-valued general register.

The decoder presents one decoded operation per instruction boundary. It supplies the operation code, the two comparison operands, the raw offset field and the general-register value for an exchange. The block evaluates the branch condition and updates the branch register and the direction bit. It then steps the PC using the updated values. The PC, the direction and the value exchanged out of the branch register are available on the next cycle. Instruction memory, opcode decode and the datapath ALU lie outside the block.

Top module: `brseq_top`

## Requirements
- R1: While the reset input is low, and until the internally synchronised release completes, the PC, the branch register and the exchange output are zero and the direction is forward (`dir_rev`=0).
- R2: In a cycle where `step_en` is low, the PC, the branch register, the direction and `swap_out` keep their values, whatever the other inputs carry.
- R3: On a step that leaves the branch register at zero, the PC rises by 1 when forward and falls by 1 when reverse.
- R4: On a step that leaves the branch register nonzero, the PC moves by the branch register's new value. It is added when forward and subtracted when reverse, modulo 2^32.
- R5: Operation codes are 4 bits: 0 none, 1 equal-branch, 2 unequal-branch, 3 non-negative, 4 positive, 5 non-positive, 6 negative, 7 long jump, 8 reverse jump, 9 exchange, and 10 to 15 none. Code 1 adds `offset[15:0]`, sign-extended to 32 bits, to the branch register when `opnd_a` equals `opnd_b`. Code 2 adds it when they differ.
- R6: Codes 3, 4, 5 and 6 add the sign-extended `offset[15:0]` when `opnd_b`, read as a signed 32-bit value, is >=0, >0, <=0 or <0 respectively. `offset[25:16]` has no effect on these codes.
- R7: A conditional code (1 to 6) whose condition is false leaves the branch register unchanged.
- R8: Code 7 adds the full 26-bit `offset`, sign-extended to 32 bits, to the branch register unconditionally.
- R9: Code 8 subtracts the sign-extended 26-bit `offset` from the branch register and sets the direction to reverse. The direction stays reverse until reset.
- R10: Code 9 loads the branch register with `swap_in` and loads `swap_out` with the branch register's prior value. `swap_out` changes on no other code.
- R11: Codes 0 and 10 to 15 leave the branch register and direction unchanged, and the PC still steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | An instruction boundary occurs this cycle |
| op | input | 4 | Decoded branch-class operation code (see R5) |
| opnd_a | input | 32 | First comparison operand |
| opnd_b | input | 32 | Second comparison operand / sign-test operand |
| offset | input | 26 | Raw offset field; low 16 bits for conditional codes |
| swap_in | input | 32 | General register value to place in the branch register |
| pc | output | 32 | Program counter after the last step |
| dir_rev | output | 1 | 1 when executing in reverse |
| swap_out | output | 32 | Branch register value exchanged out by the last exchange |

## Verification
The bench aims at the zero boundary of the sign tests, and at a negative operand with its top bit set. A design that compared operands unsigned would take the positive-branch on 0x8000_0000. It also drives junk in the upper offset bits on a short branch. A design that sign-extended the wrong field would then add a huge offset and send the PC far off. Exchange steps return the branch register to zero, and the bench checks that the PC falls back to single steps in both directions. A design that stepped the PC with the stale branch value, or with the direction before a reverse jump, would be off by the new offset on exactly those steps. A cycle with `step_en` low and a jump on the bus must leave the PC still.

// File: rtl/brseq_pkg.sv
package brseq_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_BEQ  = 4'd1,
    OP_BNE  = 4'd2,
    OP_BGEZ = 4'd3,
    OP_BGTZ = 4'd4,
    OP_BLEZ = 4'd5,
    OP_BLTZ = 4'd6,
    OP_BRA  = 4'd7,
    OP_RBRA = 4'd8,
    OP_SWAP = 4'd9
  } br_op_e;
endpackage

// File: rtl/brseq_rstsync.sv
module brseq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_ok_n = chain_q[STAGES-1];
endmodule

// File: rtl/brseq_cond.sv
module brseq_cond
  import brseq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_op_e          op,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            is_cond,
  output logic            taken
);
  logic b_neg, b_zero;

  assign b_neg  = opnd_b[XLEN-1];
  assign b_zero = (opnd_b == '0);

  always_comb begin
    is_cond = 1'b1;
    taken   = 1'b0;
    unique case (op)
      OP_BEQ:  taken = (opnd_a == opnd_b);
      OP_BNE:  taken = (opnd_a != opnd_b);
      OP_BGEZ: taken = !b_neg;
      OP_BGTZ: taken = !b_neg && !b_zero;
      OP_BLEZ: taken = b_neg || b_zero;
      OP_BLTZ: taken = b_neg;
      default: is_cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/brseq_breg.sv
module brseq_breg
  import brseq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int SOFF_W = 16,
  parameter int LOFF_W = 26
) (
  input  logic              clk,
  input  logic              rst_ok_n,
  input  logic              step_en,
  input  br_op_e            op,
  input  logic              is_cond,
  input  logic              taken,
  input  logic [LOFF_W-1:0] offset,
  input  logic [XLEN-1:0]   swap_in,
  output logic [XLEN-1:0]   br_next,
  output logic              rev_next,
  output logic              rev_q,
  output logic [XLEN-1:0]   swap_out
);
  localparam int SPAD = XLEN - SOFF_W;
  localparam int LPAD = XLEN - LOFF_W;

  logic [XLEN-1:0] br_q, sw_next, soff_x, loff_x;

  assign soff_x = {{SPAD{offset[SOFF_W-1]}}, offset[SOFF_W-1:0]};
  assign loff_x = {{LPAD{offset[LOFF_W-1]}}, offset};

  always_comb begin
    br_next  = br_q;
    rev_next = rev_q;
    sw_next  = swap_out;
    if (is_cond) begin
      if (taken) br_next = br_q + soff_x;
    end else begin
      case (op)
        OP_BRA:  br_next = br_q + loff_x;
        OP_RBRA: begin
          br_next  = br_q - loff_x;
          rev_next = 1'b1;
        end
        OP_SWAP: begin
          br_next = swap_in;
          sw_next = br_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      br_q     <= '0;
      rev_q    <= 1'b0;
      swap_out <= '0;
    end else if (step_en) begin
      br_q     <= br_next;
      rev_q    <= rev_next;
      swap_out <= sw_next;
    end
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !step_en |=> $stable(br_q) && $stable(rev_q) && $stable(swap_out));
  // R7
  untaken_keep_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    step_en && is_cond && !taken |=> $stable(br_q));
  // R9
  rev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rev_q |=> rev_q);
  // R9
  rbra_rev_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    step_en && op == OP_RBRA |=> rev_q);
  // R10
  swap_xchg_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    step_en && op == OP_SWAP |=> swap_out == $past(br_q) && br_q == $past(swap_in));
endmodule

// File: rtl/brseq_pcstep.sv
module brseq_pcstep #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_ok_n,
  input  logic            step_en,
  input  logic [XLEN-1:0] br_next,
  input  logic            rev_next,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic [XLEN-1:0] stride, pc_next;

  always_comb begin
    stride  = (br_next == '0) ? ONE : br_next;
    pc_next = rev_next ? (pc - stride) : (pc + stride);
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)    pc <= '0;
    else if (step_en) pc <= pc_next;
  end

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    step_en && br_next == '0 |=> pc == ($past(rev_next) ? $past(pc) - ONE : $past(pc) + ONE));
  // R2
  pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !step_en |=> $stable(pc));
endmodule

// File: rtl/brseq_top.sv
module brseq_top
  import brseq_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int SOFF_W     = 16,
  parameter int LOFF_W     = 26,
  parameter int OP_W       = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [OP_W-1:0]   op,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [LOFF_W-1:0] offset,
  input  logic [XLEN-1:0]   swap_in,
  output logic [XLEN-1:0]   pc,
  output logic              dir_rev,
  output logic [XLEN-1:0]   swap_out
);
  logic            rst_ok_n, is_cond, taken, rev_next;
  logic [XLEN-1:0] br_next;
  br_op_e          op_e;

  assign op_e = br_op_e'(op);

  brseq_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok_n(rst_ok_n));

  brseq_cond #(.XLEN(XLEN)) u_cond (
    .op(op_e), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .is_cond(is_cond), .taken(taken));

  brseq_breg #(.XLEN(XLEN), .SOFF_W(SOFF_W), .LOFF_W(LOFF_W)) u_breg (
    .clk(clk), .rst_ok_n(rst_ok_n), .step_en(step_en), .op(op_e),
    .is_cond(is_cond), .taken(taken), .offset(offset), .swap_in(swap_in),
    .br_next(br_next), .rev_next(rev_next), .rev_q(dir_rev),
    .swap_out(swap_out));

  brseq_pcstep #(.XLEN(XLEN)) u_pc (
    .clk(clk), .rst_ok_n(rst_ok_n), .step_en(step_en),
    .br_next(br_next), .rev_next(rev_next), .pc(pc));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_ok_n |-> pc == '0 && !dir_rev && swap_out == '0);
endmodule

// File: tb/brseq_top_tb.sv
module brseq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [3:0]  op;
  logic [31:0] opnd_a, opnd_b, swap_in;
  logic [25:0] offset;
  logic [31:0] pc, swap_out;
  logic        dir_rev;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_pc, m_br, m_sw;
  logic        m_rev;

  logic [31:0] q_pc[$], q_sw[$];
  logic        q_rev[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  brseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .offset(offset), .swap_in(swap_in),
    .pc(pc), .dir_rev(dir_rev), .swap_out(swap_out));

  task automatic compare(string tag, logic [31:0] e_pc, logic e_rev, logic [31:0] e_sw);
    checks++;
    if (pc !== e_pc || dir_rev !== e_rev || swap_out !== e_sw) begin
      fails++;
      $display("FAIL %s: pc=%h rev=%b swap=%h expected pc=%h rev=%b swap=%h",
               tag, pc, dir_rev, swap_out, e_pc, e_rev, e_sw);
    end
  endtask

  // Driver: applies one boundary, updates the model, queues the expectation
  task automatic step(string tag, bit en, logic [3:0] c, logic [31:0] a,
                      logic [31:0] b, logic [25:0] off, logic [31:0] sw);
    logic [31:0] s16, s26, stride;
    logic        tk;
    @(negedge clk);
    step_en = en; op = c; opnd_a = a; opnd_b = b; offset = off; swap_in = sw;
    s16 = {{16{off[15]}}, off[15:0]};
    s26 = {{6{off[25]}}, off};
    if (en) begin
      tk = 1'b0;
      case (c)
        4'd1: tk = (a == b);
        4'd2: tk = (a != b);
        4'd3: tk = ($signed(b) >= 0);
        4'd4: tk = ($signed(b) > 0);
        4'd5: tk = ($signed(b) <= 0);
        4'd6: tk = ($signed(b) < 0);
        4'd7: m_br = m_br + s26;
        4'd8: begin m_br = m_br - s26; m_rev = 1'b1; end
        4'd9: begin m_sw = m_br; m_br = sw; end
        default: ;
      endcase
      if (tk) m_br = m_br + s16;
      stride = (m_br == 32'd0) ? 32'd1 : m_br;
      m_pc = m_rev ? m_pc - stride : m_pc + stride;
    end
    q_pc.push_back(m_pc); q_rev.push_back(m_rev);
    q_sw.push_back(m_sw); q_tag.push_back(tag);
  endtask

  // Monitor: pops one expectation per clock after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_pc.size() > 0)
        compare(q_tag.pop_front(), q_pc.pop_front(), q_rev.pop_front(), q_sw.pop_front());
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b0; op = 4'd0;
    opnd_a = '0; opnd_b = '0; offset = '0; swap_in = '0;
    m_pc = '0; m_br = '0; m_sw = '0; m_rev = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset", 32'd0, 1'b0, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 after release", 32'd0, 1'b0, 32'd0);

    step("R3 unit step", 1, 4'd0, 0, 0, 0, 0);
    step("R3 unit step", 1, 4'd0, 0, 0, 0, 0);
    step("R5 equal taken", 1, 4'd1, 32'd7, 32'd7, 26'd5, 0);
    step("R4 br stride", 1, 4'd0, 0, 0, 0, 0);
    step("R7 unequal not taken", 1, 4'd2, 32'd7, 32'd7, 26'd100, 0);
    step("R5 unequal taken neg off", 1, 4'd2, 32'd3, 32'd4, 26'h000FFFD, 0);
    step("R6 nonneg at zero", 1, 4'd3, 0, 32'd0, 26'd1, 0);
    step("R7 positive at zero", 1, 4'd4, 0, 32'd0, 26'd1, 0);
    step("R6 nonpos upper junk", 1, 4'd5, 0, 32'hFFFF_FFFF, 26'h3FF0001, 0);
    step("R7 negative on one", 1, 4'd6, 0, 32'd1, 26'd9, 0);
    step("R6 signed top bit", 1, 4'd4, 0, 32'h8000_0000, 26'd50, 0);
    step("R6 negative top bit", 1, 4'd6, 0, 32'h8000_0000, 26'h2AB0002, 0);
    step("R10 exchange clears", 1, 4'd9, 0, 0, 0, 32'd0);
    step("R3 resume single", 1, 4'd0, 0, 0, 0, 0);
    step("R11 unused code", 1, 4'd12, 32'd1, 32'd1, 26'd77, 32'd55);
    step("R2 idle with jump", 0, 4'd7, 0, 0, 26'd33, 0);
    step("R2 idle with exchange", 0, 4'd9, 0, 0, 0, 32'd99);
    step("R8 long jump neg", 1, 4'd7, 0, 0, 26'h3FFFFFE, 0);
    step("R4 negative stride", 1, 4'd0, 0, 0, 0, 0);
    step("R10 exchange out neg", 1, 4'd9, 0, 0, 0, 32'd0);
    step("R8 long jump wide", 1, 4'd7, 0, 0, 26'h0012345, 0);
    step("R10 exchange back", 1, 4'd9, 0, 0, 0, 32'd10);
    step("R9 reverse jump", 1, 4'd8, 0, 0, 26'd4, 0);
    step("R4 reverse stride", 1, 4'd0, 0, 0, 0, 0);
    step("R10 exchange in reverse", 1, 4'd9, 0, 0, 0, 32'd0);
    step("R3 reverse unit", 1, 4'd0, 0, 0, 0, 0);
    step("R9 sticky reverse", 1, 4'd7, 0, 0, 26'd3, 0);
    step("R9 reverse to zero", 1, 4'd8, 0, 0, 26'd3, 0);
    step("R11 code ten", 1, 4'd10, 0, 0, 26'd5, 32'd7);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule